// File: doc/BRIEF.md
# Clock Alarm and Interrupt Flag Unit

This unit sits beside the time-of-day counters of a real-time clock. It stores the three alarm bytes (seconds, minutes, hours), two control bytes and a status byte. Each time the counters finish a refresh they pulse `refresh` with the new time on `now_sec`, `now_min` and `now_hour`. The unit then compares that time with the alarm bytes and records an update event. A periodic rate divider elsewhere pulses `per_tick`, and the unit records that as well. An alarm byte whose two top bits are both one matches any value. Otherwise the byte is read as BCD or as plain binary, depending on the format bit of the second control byte.

The status byte drives `irq` as a level. Software reads the status byte through the register port. That read returns the current flags, clears all of them on the following clock edge and drops `irq`. Register access is a plain strobe port with no back-pressure. A read returns `rd_data` combinationally in the same cycle as `rd_en`. A write takes effect at the clock edge. `soft_clr` is a synchronous clear of the interrupt state. `rst_n` is the asynchronous power-up reset.

Top module: `rtc_irq_status`

## Requirements
- R1: After `rst_n` the register at index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80, and `irq` is low.
- R2: The alarm bytes at indices 1 (seconds), 3 (minutes) and 5 (hours) accept any written value and read it back unchanged.
- R3: On a `refresh` pulse where the alarm enable (index 11 bit 5) is set and all three alarm fields match, status bit 7 and bit 5 are set on the next edge and `irq` goes high. Index 11 bit 2 selects the alarm format: 0 means BCD, 1 means binary. With the alarm enable clear, a match sets neither bit.
- R4: An alarm byte with bits 7:6 equal to 2'b11 matches any current value of its field.
- R5: If any non-wildcard alarm field differs from the current time, status bit 5 stays clear.
- R6: Every `refresh` pulse sets status bit 4. Status bit 7 is also set, and `irq` raised, only when the update enable (index 11 bit 4) is set.
- R7: A `per_tick` pulse with the periodic enable (index 11 bit 6) set sets status bits 7 and 6 and raises `irq`. With that enable clear, the pulse has no effect.
- R8: A read of index 12 returns the current status byte. The status byte is zero after that edge and `irq` is low.
- R9: Writes to index 12 and index 13 have no effect. Index 13 always reads 0x80.
- R10: A `soft_clr` pulse clears index 11 bits 6, 5 and 3, leaves the other bits of index 11 unchanged, clears all status flags and drops `irq`.
- R11: If an event arrives in the same cycle as a read of index 12, the read returns the old value and the flags of that event remain set after the edge.
- R12: Index 10 bit 7 cannot be written. Bits 6:0 take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| soft_clr | input | 1 | Synchronous clear of enables and flags |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index to write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a read of index 12 clears status |
| rd_idx | input | IDX_W | Register index to read |
| rd_data | output | 8 | Read data, valid in the same cycle as rd_en |
| refresh | input | 1 | Pulse: the time counters completed a refresh |
| per_tick | input | 1 | Pulse from the periodic rate divider |
| now_sec | input | SEC_W | Current seconds, binary |
| now_min | input | MIN_W | Current minutes, binary |
| now_hour | input | HR_W | Current hours, binary, 0 to 23 |
| irq | output | 1 | Level interrupt request |

## Verification
The clear-on-read of the status byte and the setting of a flag by an incoming event can fall in the same clock cycle. The bench provokes this by strobing a read of index 12 together with a `per_tick` pulse while the periodic enable is set. It judges the result in two steps. First, the read data sampled during that cycle must be the old value, zero. Second, after the edge `irq` must be high and a following read must return 0xC0, which shows that the event survived the clear.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
  localparam int BYTE_W = 8;

  // register indices
  localparam int IX_ALM_SEC = 1;
  localparam int IX_ALM_MIN = 3;
  localparam int IX_ALM_HR  = 5;
  localparam int IX_CTLA    = 10;
  localparam int IX_CTLB    = 11;
  localparam int IX_STAT    = 12;
  localparam int IX_VALID   = 13;

  // control B bit positions
  localparam int CB_PER_EN = 6;
  localparam int CB_ALM_EN = 5;
  localparam int CB_UPD_EN = 4;
  localparam int CB_SQW_EN = 3;
  localparam int CB_BIN    = 2;

  // status bit positions
  localparam int ST_ANY = 7;
  localparam int ST_PER = 6;
  localparam int ST_ALM = 5;
  localparam int ST_UPD = 4;

  localparam logic [BYTE_W-1:0] CTLA_INIT   = 8'h26;
  localparam logic [BYTE_W-1:0] CTLB_INIT   = 8'h02;
  localparam logic [BYTE_W-1:0] VALID_CONST = 8'h80;

  function automatic logic [BYTE_W-1:0] alarm_decode(input logic [BYTE_W-1:0] b,
                                                     input logic bin);
    logic [BYTE_W-1:0] tens;
    tens = {4'b0, b[7:4]};
    if (bin) return b;
    return (tens * 8'd10) + {4'b0, b[3:0]};
  endfunction
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import rtcirq_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctla,
  output logic [BYTE_W-1:0] ctlb,
  output logic [BYTE_W-1:0] alm_sec,
  output logic [BYTE_W-1:0] alm_min,
  output logic [BYTE_W-1:0] alm_hr
);
  logic [BYTE_W-1:0] clr_mask;
  always_comb begin
    clr_mask = '1;
    clr_mask[CB_PER_EN] = 1'b0;
    clr_mask[CB_ALM_EN] = 1'b0;
    clr_mask[CB_SQW_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla    <= CTLA_INIT;
      ctlb    <= CTLB_INIT;
      alm_sec <= '0;
      alm_min <= '0;
      alm_hr  <= '0;
    end else if (soft_clr) begin
      ctlb <= ctlb & clr_mask;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(IX_ALM_SEC)) alm_sec <= wr_data;
      if (wr_idx == IDX_W'(IX_ALM_MIN)) alm_min <= wr_data;
      if (wr_idx == IDX_W'(IX_ALM_HR))  alm_hr  <= wr_data;
      if (wr_idx == IDX_W'(IX_CTLA))    ctla    <= {ctla[7], wr_data[6:0]};
      if (wr_idx == IDX_W'(IX_CTLB))    ctlb    <= wr_data;
    end
  end

  assert_ctla_top_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IX_CTLA)) |=> $stable(ctla[7]));

  assert_softclr_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!ctlb[CB_PER_EN] && !ctlb[CB_ALM_EN] && !ctlb[CB_SQW_EN]));
endmodule

// File: rtl/irq_alarm_cmp.sv
module irq_alarm_cmp
  import rtcirq_pkg::*;
#(
  parameter int SEC_W = 6,
  parameter int MIN_W = 6,
  parameter int HR_W  = 5
) (
  input  logic [BYTE_W-1:0] alm_sec,
  input  logic [BYTE_W-1:0] alm_min,
  input  logic [BYTE_W-1:0] alm_hr,
  input  logic              bin_mode,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HR_W-1:0]   now_hour,
  output logic              hit
);
  localparam int NF = 3;

  logic [BYTE_W-1:0] alm_arr [NF];
  logic [BYTE_W-1:0] cur_arr [NF];
  logic [NF-1:0]     fld_ok;

  assign alm_arr[0] = alm_sec;
  assign alm_arr[1] = alm_min;
  assign alm_arr[2] = alm_hr;
  assign cur_arr[0] = BYTE_W'(now_sec);
  assign cur_arr[1] = BYTE_W'(now_min);
  assign cur_arr[2] = BYTE_W'(now_hour);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic wild;
    assign wild      = &alm_arr[i][7:6];
    assign fld_ok[i] = wild || (alarm_decode(alm_arr[i], bin_mode) == cur_arr[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import rtcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              refresh,
  input  logic              per_tick,
  input  logic              alarm_hit,
  input  logic              per_en,
  input  logic              alm_en,
  input  logic              upd_en,
  input  logic              rd_clear,
  output logic [BYTE_W-1:0] status,
  output logic              irq
);
  logic [BYTE_W-1:0] set_vec;
  logic              ev_alm, ev_per, ev_upd_irq;

  always_comb begin
    ev_alm     = refresh && alm_en && alarm_hit;
    ev_per     = per_tick && per_en;
    ev_upd_irq = refresh && upd_en;
    set_vec         = '0;
    set_vec[ST_UPD] = refresh;
    set_vec[ST_ALM] = ev_alm;
    set_vec[ST_PER] = ev_per;
    set_vec[ST_ANY] = ev_alm || ev_per || ev_upd_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (soft_clr) status <= '0;
    else               status <= (rd_clear ? '0 : status) | set_vec;
  end

  assign irq = status[ST_ANY];

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !refresh && !per_tick) |=> (status == '0 && !irq));

  assert_update_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !soft_clr) |=> status[ST_UPD]);

  assert_periodic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick && per_en && !soft_clr) |=> (status[ST_PER] && irq));

  assert_alarm_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && alm_en && alarm_hit && !soft_clr) |=> (status[ST_ALM] && irq));

  assert_alarm_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ALM]) |-> $past(alm_en && refresh));

  assert_event_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && per_tick && per_en && !soft_clr) |=> status[ST_PER]);

  assert_softclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (status == '0 && !irq));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtcirq_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int SEC_W = 6,
  parameter int MIN_W = 6,
  parameter int HR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              refresh,
  input  logic              per_tick,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HR_W-1:0]   now_hour,
  output logic              irq
);
  logic [BYTE_W-1:0] ctla, ctlb, alm_sec, alm_min, alm_hr, status;
  logic              hit, rd_clear;

  irq_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ctla(ctla), .ctlb(ctlb),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr)
  );

  irq_alarm_cmp #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)) u_cmp (
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .bin_mode(ctlb[CB_BIN]),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .hit(hit)
  );

  assign rd_clear = rd_en && (rd_idx == IDX_W'(IX_STAT));

  irq_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .refresh(refresh), .per_tick(per_tick), .alarm_hit(hit),
    .per_en(ctlb[CB_PER_EN]), .alm_en(ctlb[CB_ALM_EN]), .upd_en(ctlb[CB_UPD_EN]),
    .rd_clear(rd_clear), .status(status), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_W'(IX_ALM_SEC)) rd_data = alm_sec;
    if (rd_idx == IDX_W'(IX_ALM_MIN)) rd_data = alm_min;
    if (rd_idx == IDX_W'(IX_ALM_HR))  rd_data = alm_hr;
    if (rd_idx == IDX_W'(IX_CTLA))    rd_data = ctla;
    if (rd_idx == IDX_W'(IX_CTLB))    rd_data = ctlb;
    if (rd_idx == IDX_W'(IX_STAT))    rd_data = status;
    if (rd_idx == IDX_W'(IX_VALID))   rd_data = VALID_CONST;
  end

  assert_status_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IX_STAT) && !rd_en && !refresh && !per_tick && !soft_clr)
      |=> $stable(status));
endmodule

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb;
  localparam int OP_WR = 0, OP_RD = 1, OP_RF = 2, OP_PT = 3, OP_RDPT = 4;
  localparam logic [23:0] T_A = {8'd30, 8'd45, 8'd13};
  localparam logic [23:0] T_B = {8'd31, 8'd45, 8'd13};
  localparam logic [23:0] T_C = {8'd10, 8'd20, 8'd13};
  localparam logic [23:0] T_0 = 24'd0;
  localparam int NV = 43;

  // {op[4], idx[8], wdata[8], time{sec,min,hr}[24], expected[8], expected irq, req[4]}
  localparam logic [56:0] VECS [NV] = '{
    {4'd1, 8'd10, 8'h00, T_0, 8'h26, 1'b0, 4'd1},  // R1
    {4'd1, 8'd11, 8'h00, T_0, 8'h02, 1'b0, 4'd1},  // R1
    {4'd1, 8'd12, 8'h00, T_0, 8'h00, 1'b0, 4'd1},  // R1
    {4'd1, 8'd13, 8'h00, T_0, 8'h80, 1'b0, 4'd1},  // R1
    {4'd0, 8'd1,  8'h30, T_0, 8'h00, 1'b0, 4'd2},  // R2
    {4'd0, 8'd3,  8'h45, T_0, 8'h00, 1'b0, 4'd2},
    {4'd0, 8'd5,  8'h13, T_0, 8'h00, 1'b0, 4'd2},
    {4'd1, 8'd1,  8'h00, T_0, 8'h30, 1'b0, 4'd2},
    {4'd1, 8'd3,  8'h00, T_0, 8'h45, 1'b0, 4'd2},
    {4'd1, 8'd5,  8'h00, T_0, 8'h13, 1'b0, 4'd2},
    {4'd2, 8'd0,  8'h00, T_A, 8'h00, 1'b0, 4'd3},  // R3 alarm disabled
    {4'd1, 8'd12, 8'h00, T_0, 8'h10, 1'b0, 4'd6},  // R6
    {4'd0, 8'd11, 8'h22, T_0, 8'h00, 1'b0, 4'd3},
    {4'd2, 8'd0,  8'h00, T_A, 8'h00, 1'b1, 4'd3},  // R3 BCD match
    {4'd1, 8'd12, 8'h00, T_0, 8'hB0, 1'b0, 4'd8},  // R8
    {4'd1, 8'd12, 8'h00, T_0, 8'h00, 1'b0, 4'd8},
    {4'd2, 8'd0,  8'h00, T_B, 8'h00, 1'b0, 4'd5},  // R5
    {4'd1, 8'd12, 8'h00, T_0, 8'h10, 1'b0, 4'd5},
    {4'd0, 8'd1,  8'hC0, T_0, 8'h00, 1'b0, 4'd4},  // R4
    {4'd2, 8'd0,  8'h00, T_B, 8'h00, 1'b1, 4'd4},
    {4'd1, 8'd12, 8'h00, T_0, 8'hB0, 1'b0, 4'd4},
    {4'd0, 8'd11, 8'h26, T_0, 8'h00, 1'b0, 4'd3},  // R3 binary
    {4'd0, 8'd1,  8'h0A, T_0, 8'h00, 1'b0, 4'd3},
    {4'd0, 8'd3,  8'h14, T_0, 8'h00, 1'b0, 4'd3},
    {4'd0, 8'd5,  8'h0D, T_0, 8'h00, 1'b0, 4'd3},
    {4'd2, 8'd0,  8'h00, T_C, 8'h00, 1'b1, 4'd3},
    {4'd1, 8'd12, 8'h00, T_0, 8'hB0, 1'b0, 4'd3},
    {4'd0, 8'd11, 8'h12, T_0, 8'h00, 1'b0, 4'd6},  // R6 update enable
    {4'd2, 8'd0,  8'h00, T_A, 8'h00, 1'b1, 4'd6},
    {4'd1, 8'd12, 8'h00, T_0, 8'h90, 1'b0, 4'd6},
    {4'd3, 8'd0,  8'h00, T_0, 8'h00, 1'b0, 4'd7},  // R7 disabled
    {4'd1, 8'd12, 8'h00, T_0, 8'h00, 1'b0, 4'd7},
    {4'd0, 8'd11, 8'h42, T_0, 8'h00, 1'b0, 4'd7},
    {4'd3, 8'd0,  8'h00, T_0, 8'h00, 1'b1, 4'd7},  // R7 enabled
    {4'd1, 8'd12, 8'h00, T_0, 8'hC0, 1'b0, 4'd7},
    {4'd0, 8'd12, 8'hFF, T_0, 8'h00, 1'b0, 4'd9},  // R9
    {4'd0, 8'd13, 8'h00, T_0, 8'h00, 1'b0, 4'd9},
    {4'd1, 8'd12, 8'h00, T_0, 8'h00, 1'b0, 4'd9},
    {4'd1, 8'd13, 8'h00, T_0, 8'h80, 1'b0, 4'd9},
    {4'd0, 8'd10, 8'hFF, T_0, 8'h00, 1'b0, 4'd12}, // R12
    {4'd1, 8'd10, 8'h00, T_0, 8'h7F, 1'b0, 4'd12},
    {4'd4, 8'd12, 8'h00, T_0, 8'h00, 1'b1, 4'd11}, // R11 read + tick
    {4'd1, 8'd12, 8'h00, T_0, 8'hC0, 1'b0, 4'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_clr = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, refresh = 1'b0, per_tick = 1'b0;
  logic [6:0] wr_idx = '0, rd_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [5:0] now_sec = '0, now_min = '0;
  logic [4:0] now_hour = '0;
  logic       irq;
  int         n_vec = 0, n_bad = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  rtc_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .refresh(refresh), .per_tick(per_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .irq(irq)
  );

  task automatic check(input string what, input int req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [7:0] idx, input logic [7:0] wd,
                       input logic [23:0] tm, input logic [7:0] exp,
                       input logic eirq, input int req);
    @(negedge clk);
    wr_idx  = idx[6:0];
    rd_idx  = idx[6:0];
    wr_data = wd;
    now_sec = tm[21:16];
    now_min = tm[13:8];
    now_hour = tm[4:0];
    wr_en    = (op == OP_WR);
    rd_en    = (op == OP_RD) || (op == OP_RDPT);
    refresh  = (op == OP_RF);
    per_tick = (op == OP_PT) || (op == OP_RDPT);
    #1;
    if (rd_en) check("read data", req, rd_data, exp);
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; refresh = 1'b0; per_tick = 1'b0;
    #1;
    check("irq level", req, {7'd0, irq}, {7'd0, eirq});
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(int'(VECS[i][56:53]), VECS[i][52:45], VECS[i][44:37], VECS[i][36:13],
            VECS[i][12:5], VECS[i][4], int'(VECS[i][3:0]));
    end

    // R10: soft clear drops enables and flags, keeps other control bits
    apply(OP_WR, 8'd11, 8'h7E, T_0, 8'h00, 1'b0, 10);
    apply(OP_PT, 8'd0, 8'h00, T_0, 8'h00, 1'b1, 10);
    @(negedge clk);
    soft_clr = 1'b1;
    @(posedge clk);
    #1 soft_clr = 1'b0;
    #1 check("irq after soft clear", 10, {7'd0, irq}, 8'd0);
    apply(OP_RD, 8'd11, 8'h00, T_0, 8'h16, 1'b0, 10);
    apply(OP_RD, 8'd12, 8'h00, T_0, 8'h00, 1'b0, 10);

    // R1: power-up reset restores control values
    apply(OP_PT, 8'd0, 8'h00, T_0, 8'h00, 1'b0, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #3 check("irq in reset", 1, {7'd0, irq}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(OP_RD, 8'd11, 8'h00, T_0, 8'h02, 1'b0, 1);
    apply(OP_RD, 8'd10, 8'h00, T_0, 8'h26, 1'b0, 1);
    apply(OP_RD, 8'd1,  8'h00, T_0, 8'h00, 1'b0, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule